// File: doc/BRIEF.md
# Baud Clock Generator with Prescaler

This block derives the two timing strobes that one serial channel needs from a single reference clock: a sample strobe at the oversampling rate and a bit strobe at the bit rate. The reference clock is first thinned by a prescaler that passes every cycle or every fourth cycle. A 16-bit divisor then counts prescaled cycles to place the sample strobe. A mode select sets the bit strobe to every 8th or every 16th sample strobe. In 8X mode the top bit rate is twice the 16X rate: a 50 MHz reference with divisor 1 gives 6.25 Mbps in 8X and 3.125 Mbps in 16X.

The transmitter and receiver of the channel consume the two strobes as clock enables. The divisor, prescaler select and mode select are sampled every cycle. Any change to them restarts all counters, so the first strobe after a change comes one full new period later and never at a leftover spacing. Both strobes come from registers and last one clock cycle.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst` is high at a rising edge, both strobes are low after that edge and all counters clear. The held configuration returns to divisor 0, divide-by-1 and 16X. After release, the first sample strobe follows the rule of R5.
- R2: With settings held constant and divisor D > 0, `sample_tick` pulses once every P·D clock cycles. P is 1 when `presc_sel` = 0 and 4 when `presc_sel` = 1.
- R3: `bit_tick` pulses together with every M-th `sample_tick`, and never without one. M is 16 when `mode_8x` = 0 and 8 when `mode_8x` = 1.
- R4: With divisor 0, neither strobe pulses.
- R5: When the settings change, counting restarts. Let E0 be the first rising edge at which the new values are present, and count it as edge 0. The first `sample_tick` is seen after edge P·D and the first `bit_tick` after edge P·D·M. Neither strobe is high after edge 0.
- R6: When P·D > 1, each `sample_tick` is high for exactly one cycle.
- R7: With divisor 1 and divide-by-1, `bit_tick` has a period of 8 cycles in 8X mode and 16 cycles in 16X mode.
- R8: The largest divisor, 65535, gives a sample period of 65535 cycles at divide-by-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| divisor | input | 16 | Prescaled cycles per sample strobe; 0 stops both strobes |
| presc_sel | input | 1 | 0: divide by 1, 1: divide by 4 |
| mode_8x | input | 1 | 0: 16 samples per bit, 1: 8 samples per bit |
| sample_tick | output | 1 | One-cycle oversampling strobe |
| bit_tick | output | 1 | One-cycle bit-rate strobe, coincident with a sample strobe |

## Verification
The assertions assume that the three setting inputs change only between clock edges and are otherwise free. The checker tracks their previous values itself, so it needs no knowledge of when software writes them. The spacing and silence properties rely on the settings holding for at least one cycle after a strobe. The bench changes settings only on falling edges and holds each setting for at least several sample periods, except for the directed mid-period change. That change is made on purpose to exercise the restart rule.

// File: rtl/baud_pkg.sv
package baud_pkg;

  // prescaler ratio select
  typedef enum logic {
    PRE_DIV1 = 1'b0,
    PRE_DIV4 = 1'b1
  } pre_sel_e;

  // oversampling mode select
  typedef enum logic {
    OVS_16X = 1'b0,
    OVS_8X  = 1'b1
  } ovs_sel_e;

endpackage

// File: rtl/baud_cfg_reg.sv
// Holds the active settings and flags a restart whenever the inputs differ
// from what the counters are currently running on.
module baud_cfg_reg
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  input  pre_sel_e         pre_i,
  input  ovs_sel_e         ovs_i,
  output logic [DIV_W-1:0] div_q,
  output pre_sel_e         pre_q,
  output ovs_sel_e         ovs_q,
  output logic             reload
);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      pre_q <= PRE_DIV1;
      ovs_q <= OVS_16X;
    end else begin
      div_q <= div_i;
      pre_q <= pre_i;
      ovs_q <= ovs_i;
    end
  end

  always_comb begin
    reload = (div_i != div_q) || (pre_i != pre_q) || (ovs_i != ovs_q);
  end

endmodule

// File: rtl/baud_prescaler.sv
// Produces a cycle enable: every cycle, or once per RATIO cycles.
module baud_prescaler
  import baud_pkg::*;
#(
  parameter int unsigned RATIO = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     clr,
  input  pre_sel_e pre_sel,
  output logic     en
);

  localparam int unsigned PW = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pcnt <= '0;
    end else if (pre_sel == PRE_DIV4) begin
      pcnt <= (pcnt == LAST) ? '0 : pcnt + PW'(1);
    end else begin
      pcnt <= '0;
    end
  end

  always_comb begin
    en = (pre_sel == PRE_DIV1) || (pcnt == LAST);
  end

endmodule

// File: rtl/baud_divider.sv
// Counts prescaled cycles up to the divisor and flags the last one.
module baud_divider #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             hit
);

  logic [DIV_W-1:0] dcnt;
  logic [DIV_W-1:0] div_m1;
  logic             div_zero;

  always_comb begin
    div_m1   = div - DIV_W'(1);
    div_zero = (div == '0);
    hit      = en && !div_zero && !clr && (dcnt == div_m1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr || div_zero) begin
      dcnt <= '0;
    end else if (en) begin
      dcnt <= hit ? '0 : dcnt + DIV_W'(1);
    end
  end

endmodule

// File: rtl/baud_oversample.sv
// Counts sample events and flags the last one of each bit period.
module baud_oversample
  import baud_pkg::*;
#(
  parameter int unsigned OVS_HI = 16,
  parameter int unsigned OVS_LO = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     clr,
  input  logic     step,
  input  ovs_sel_e ovs_sel,
  output logic     wrap
);

  localparam int unsigned OW = $clog2(OVS_HI);
  localparam logic [OW-1:0] LAST_HI = OW'(OVS_HI - 1);
  localparam logic [OW-1:0] LAST_LO = OW'(OVS_LO - 1);

  logic [OW-1:0] ocnt;
  logic [OW-1:0] last;

  always_comb begin
    last = (ovs_sel == OVS_8X) ? LAST_LO : LAST_HI;
    wrap = step && (ocnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ocnt <= '0;
    end else if (step) begin
      ocnt <= wrap ? '0 : ocnt + OW'(1);
    end
  end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned PRE_RATIO = 4,
  parameter int unsigned OVS_HI    = 16,
  parameter int unsigned OVS_LO    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  input  logic             presc_sel,
  input  logic             mode_8x,
  output logic             sample_tick,
  output logic             bit_tick
);

  logic [DIV_W-1:0] div_q;
  pre_sel_e         pre_q;
  ovs_sel_e         ovs_q;
  logic             reload;
  logic             pre_en;
  logic             samp_hit;
  logic             bit_hit;

  baud_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .div_i  (divisor),
    .pre_i  (pre_sel_e'(presc_sel)),
    .ovs_i  (ovs_sel_e'(mode_8x)),
    .div_q  (div_q),
    .pre_q  (pre_q),
    .ovs_q  (ovs_q),
    .reload (reload)
  );

  baud_prescaler #(.RATIO(PRE_RATIO)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .clr     (reload),
    .pre_sel (pre_q),
    .en      (pre_en)
  );

  baud_divider #(.DIV_W(DIV_W)) u_div (
    .clk (clk),
    .rst (rst),
    .clr (reload),
    .en  (pre_en),
    .div (div_q),
    .hit (samp_hit)
  );

  baud_oversample #(.OVS_HI(OVS_HI), .OVS_LO(OVS_LO)) u_ovs (
    .clk     (clk),
    .rst     (rst),
    .clr     (reload),
    .step    (samp_hit),
    .ovs_sel (ovs_q),
    .wrap    (bit_hit)
  );

  // registered strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      sample_tick <= 1'b0;
      bit_tick    <= 1'b0;
    end else begin
      sample_tick <= samp_hit;
      bit_tick    <= bit_hit;
    end
  end

endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk #(
  parameter int unsigned DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [DIV_W-1:0] divisor,
  input logic             presc_sel,
  input logic             mode_8x,
  input logic             sample_tick,
  input logic             bit_tick
);

  logic [DIV_W-1:0] prev_div;
  logic             prev_pre;
  logic             prev_mode;
  logic             chg;
  logic             chg_q;

  always_comb begin
    chg = (divisor != prev_div) || (presc_sel != prev_pre) || (mode_8x != prev_mode);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_div  <= '0;
      prev_pre  <= 1'b0;
      prev_mode <= 1'b0;
      chg_q     <= 1'b0;
    end else begin
      prev_div  <= divisor;
      prev_pre  <= presc_sel;
      prev_mode <= mode_8x;
      chg_q     <= chg;
    end
  end

  AST_DIV0_SILENT: assert property (@(posedge clk) disable iff (rst)
    (divisor == '0 && prev_div == '0) |=> (!sample_tick && !bit_tick)); // R4

  AST_RELOAD_GAP: assert property (@(posedge clk) disable iff (rst)
    chg_q |-> (!sample_tick && !bit_tick)); // R5

  AST_BIT_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> sample_tick); // R3

  AST_BIT_SPACING: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick); // R3

  AST_DIV4_SPACING: assert property (@(posedge clk) disable iff (rst)
    (sample_tick && presc_sel) |=> !sample_tick); // R2

  AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (sample_tick && divisor > DIV_W'(1)) |=> !sample_tick); // R6

endmodule

bind baud_tick_gen baud_tick_chk #(.DIV_W(DIV_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .divisor     (divisor),
  .presc_sel   (presc_sel),
  .mode_8x     (mode_8x),
  .sample_tick (sample_tick),
  .bit_tick    (bit_tick)
);

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] divisor = 16'd0;
  logic        presc_sel = 1'b0;
  logic        mode_8x = 1'b0;
  logic        sample_tick;
  logic        bit_tick;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  baud_tick_gen i_baud_tick_gen (
    .clk         (clk),
    .rst         (rst),
    .divisor     (divisor),
    .presc_sel   (presc_sel),
    .mode_8x     (mode_8x),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick)
  );

  // divisor, presc_sel, mode_8x, expected sample period, samples per bit
  localparam int VEC [0:7][0:4] = '{
    '{1, 0, 1,  1,  8},
    '{1, 0, 0,  1, 16},
    '{3, 0, 1,  3,  8},
    '{2, 1, 0,  8, 16},
    '{5, 0, 0,  5, 16},
    '{1, 1, 1,  4,  8},
    '{4, 1, 1, 16,  8},
    '{7, 0, 1,  7,  8}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called just after a falling edge at which settings were applied.
  // Edge index 0 is the next rising edge; results are edge indices.
  task automatic observe(input int lim, input bit first_only,
                         output int s1, output int s2, output int b1,
                         output bit bs, output int wide);
    bit prev_s = 1'b0;
    s1 = -1; s2 = -1; b1 = -1; bs = 1'b0; wide = 0;
    for (int c = 0; c < lim; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (sample_tick && prev_s) wide++;
      prev_s = sample_tick;
      if (sample_tick) begin
        if (s1 < 0) s1 = c;
        else if (s2 < 0) s2 = c;
      end
      if (bit_tick && b1 < 0) begin
        b1 = c;
        bs = sample_tick;
      end
      if (first_only && s1 >= 0) break;
      if (s2 >= 0 && b1 >= 0) break;
    end
  endtask

  task automatic apply(input int d, input bit p, input bit m);
    divisor   = 16'(d);
    presc_sel = p;
    mode_8x   = m;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int s1, s2, b1, wide, quiet;
    bit bs;

    // R1: reset holds strobes low even with a live setting
    @(negedge clk);
    apply(1, 0, 1);
    quiet = 0;
    repeat (6) begin
      @(negedge clk);
      if (sample_tick || bit_tick) quiet++;
    end
    chk(quiet == 0, "R1 strobes during reset", quiet, 0);

    // R1: after release counting starts from cleared state
    apply(2, 0, 1);
    rst = 1'b0;
    observe(100, 1'b0, s1, s2, b1, bs, wide);
    chk(s1 == 2, "R1 first sample after release", s1, 2);
    chk(b1 == 16, "R1 first bit after release", b1, 16);

    // vector table: R2 R3 R5 R6 R7
    for (int i = 0; i < 8; i++) begin
      int per, rat;
      per = VEC[i][3];
      rat = VEC[i][4];
      apply(VEC[i][0], VEC[i][1] != 0, VEC[i][2] != 0);
      observe(per * rat + 4 * per + 10, 1'b0, s1, s2, b1, bs, wide);
      chk(s1 == per, "R5 first sample edge", s1, per);
      chk(s2 - s1 == per, "R2 sample period", s2 - s1, per);
      chk(b1 == per * rat, "R3 first bit edge", b1, per * rat);
      chk(bs == 1'b1, "R3 bit with sample", int'(bs), 1);
      if (per > 1) chk(wide == 0, "R6 single cycle sample", wide, 0);
      if (VEC[i][0] == 1 && VEC[i][1] == 0)
        chk(b1 == rat, "R7 top rate bit period", b1, rat);
    end

    // R4: divisor zero stops both strobes
    apply(0, 0, 1);
    observe(300, 1'b0, s1, s2, b1, bs, wide);
    chk(s1 == -1, "R4 no sample with divisor 0", s1, -1);
    chk(b1 == -1, "R4 no bit with divisor 0", b1, -1);

    // R5: mid-period change restarts with the new period
    apply(5, 0, 0);
    repeat (7) @(negedge clk);
    apply(3, 0, 0);
    observe(200, 1'b0, s1, s2, b1, bs, wide);
    chk(s1 == 3, "R5 restart after mid-period change", s1, 3);
    chk(b1 == 48, "R5 bit after mid-period change", b1, 48);

    // R1: reset during operation clears counters
    repeat (5) @(negedge clk);
    rst = 1'b1;
    quiet = 0;
    repeat (3) begin
      @(negedge clk);
      if (sample_tick || bit_tick) quiet++;
    end
    chk(quiet == 0, "R1 strobes during mid-run reset", quiet, 0);
    rst = 1'b0;
    observe(200, 1'b0, s1, s2, b1, bs, wide);
    chk(s1 == 3, "R1 first sample after mid-run reset", s1, 3);
    chk(b1 == 48, "R1 first bit after mid-run reset", b1, 48);

    // R8: largest divisor
    apply(65535, 0, 0);
    observe(70000, 1'b1, s1, s2, b1, bs, wide);
    chk(s1 == 65535, "R8 largest divisor period", s1, 65535);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule